// File: doc/BRIEF.md
# Audio Engine Control and Status Register Block

This block sits between an 8-bit microcontroller's external byte bus and an audio record and playback engine. It gives the CPU four byte registers at consecutive addresses. Through them the CPU enables the engine, picks record or playback mode, sets the disk transfer direction, hands the disk bus to the engine, holds the engine in soft reset or starts it, and turns on a fast-forward mode that skips packets. The engine reports back through status inputs: an interrupt request, a transfer-done pulse and a playing-busy level. The block drives a level interrupt line to the CPU.

Several bits mean one thing when read and another when written. The side effects are part of the register behaviour. A read of the interrupt register in record mode clears the pending interrupt. A write sequence that takes the header bit from 1 to 0 produces a one-cycle clear pulse for the engine's header flag. Writing 0 to the run bit puts the engine in soft reset, and this also drops the bus hand-over and the interrupt held in this block. To start the engine, firmware writes run=0, then writes the mode, then writes run=1.

Top module: `aud_ctl_regs`

## Requirements
- R1: After reset, every control output is 0 except `eng_soft_rst`, which is 1. `cpu_irq` and `hdr_clr` are 0, and reads of all four registers return 0 apart from the live busy bit.
- R2: Register offset 0, bit 0, is written active-low. Writing 0 sets `eng_enable` to 1 and writing 1 sets it to 0, from the cycle after the write.
- R3: An `eng_irq_set` pulse while running sets the interrupt, and `cpu_irq` stays high until the interrupt is cleared. Offset 0 reads the interrupt in bit 0. A read of offset 0 while the mode is record (0) clears the interrupt. The same read in playback mode leaves it set.
- R4: When `eng_irq_set` and a clearing read of offset 0 fall in the same cycle, the interrupt ends up set.
- R5: Offset 1, bit 0, is read/write. Writing 1 hands the disk bus to the engine and the bit then reads 1. An `eng_xfer_done` pulse returns it to 0 with no CPU write. Bit 1 is write-only: it drives `eng_dir_play` (0 record to disk, 1 play from disk) and reads 0.
- R6: Offset 2, bit 0, is the read/write mode (`eng_mode_play`, 0 record, 1 playback). Bit 1 reads the interrupt status in record mode and reads 0 in playback mode.
- R7: Write offset 2 with bit 1 = 1, then write offset 2 with bit 1 = 0, and `hdr_clr` is high for exactly the one cycle after the second write. A 0 write that does not follow a 1 write produces no pulse.
- R8: Offset 3, bit 0, is the run bit. `eng_run` follows it and `eng_soft_rst` is its inverse. Writing 0 clears the interrupt and the bus hand-over. `eng_irq_set` is ignored while the block is in soft reset.
- R9: Offset 3, bit 1, reads the `eng_busy` input live. Writing it sets `eng_skip`: 1 skips packets, 0 restores normal playback.
- R10: Register bits not listed read 0, and writes to them change nothing. An access to an address outside base..base+3 changes no state and reads 0. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| eng_irq_set | input | 1 | Engine interrupt request pulse |
| eng_xfer_done | input | 1 | Engine finished its disk transfer (pulse) |
| eng_busy | input | 1 | Engine is outputting playback data |
| eng_enable | output | 1 | Engine enable |
| eng_mode_play | output | 1 | 0 record, 1 playback |
| eng_dir_play | output | 1 | Disk transfer direction |
| eng_bus_own | output | 1 | Disk bus handed to the engine |
| eng_run | output | 1 | Engine running |
| eng_soft_rst | output | 1 | Engine held in soft reset |
| eng_skip | output | 1 | Fast-forward packet skip |
| hdr_clr | output | 1 | One-cycle header-flag clear pulse |
| cpu_irq | output | 1 | Level interrupt to the CPU |

## Verification
The assertions take two things about the inputs for granted. First, `bus_rd` and `bus_wr` are never high in the same cycle. Second, the interrupt and bus-hand-over properties hold only in cycles without a bus write, because a write to the run bit in that cycle would legitimately override them. The random stimulus follows the first rule on every cycle. It draws addresses mostly inside the window with some outside it, and it pulses the engine inputs independently of bus activity, so both the same-cycle races and the write-free cycles occur often.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BUS  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_RUN  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic mode;
        logic dir;
        logic run;
        logic skip;
        logic own;
    } ctl_state_t;

    localparam int DATA_W = 8;
endpackage

// File: rtl/aud_addr_dec.sv
module aud_addr_dec
    import aud_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);
    localparam int HI = ADDR_W - 1;

    always_comb begin
        hit = (addr[HI:2] == BASE[HI:2]);
        sel = reg_sel_e'(addr[1:0]);
    end
endmodule

// File: rtl/aud_irq_ctl.sv
module aud_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_q,
    input  logic run_d,
    input  logic set_req,
    input  logic rd_clr,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (rd_clr)            irq_d = 1'b0;
        if (set_req && run_q)  irq_d = 1'b1;
        if (!run_d)            irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R4: engine set beats a same-cycle clearing read
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && run_q && run_d) |=> irq);
    // R3: clearing read with no concurrent set drops the interrupt
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_req) |=> !irq);
endmodule

// File: rtl/aud_hdr_arm.sv
module aud_hdr_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_mode,
    input  logic wbit,
    output logic clr_pulse
);
    typedef struct packed {
        logic arm;
        logic pulse;
    } hdr_t;

    hdr_t s_d, s_q;

    always_comb begin
        s_d.arm   = wr_mode ? wbit : s_q.arm;
        s_d.pulse = wr_mode && !wbit && s_q.arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clr_pulse = s_q.pulse;

    // R7: the clear is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);
endmodule

// File: rtl/aud_ctl_regs.sv
module aud_ctl_regs
    import aud_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    input  logic              eng_irq_set,
    input  logic              eng_xfer_done,
    input  logic              eng_busy,
    output logic              eng_enable,
    output logic              eng_mode_play,
    output logic              eng_dir_play,
    output logic              eng_bus_own,
    output logic              eng_run,
    output logic              eng_soft_rst,
    output logic              eng_skip,
    output logic              hdr_clr,
    output logic              cpu_irq
);
    logic     hit;
    reg_sel_e sel;
    logic     wr_hit, rd_hit, rd_clr, irq;
    ctl_state_t s_d, s_q;
    logic     unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:2];

    aud_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    assign wr_hit = bus_wr && hit;
    assign rd_hit = bus_rd && hit;
    assign rd_clr = rd_hit && (sel == SEL_CTRL) && !s_q.mode;

    always_comb begin
        s_d = s_q;
        if (eng_xfer_done) s_d.own = 1'b0;
        if (wr_hit) begin
            unique case (sel)
                SEL_CTRL: s_d.en = ~bus_wdata[0];
                SEL_BUS: begin
                    s_d.own = bus_wdata[0];
                    s_d.dir = bus_wdata[1];
                end
                SEL_MODE: s_d.mode = bus_wdata[0];
                SEL_RUN: begin
                    s_d.run  = bus_wdata[0];
                    s_d.skip = bus_wdata[1];
                end
                default: ;
            endcase
        end
        if (!s_d.run) s_d.own = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    aud_irq_ctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_q   (s_q.run),
        .run_d   (s_d.run),
        .set_req (eng_irq_set),
        .rd_clr  (rd_clr),
        .irq     (irq)
    );

    aud_hdr_arm u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_hit && (sel == SEL_MODE)),
        .wbit      (bus_wdata[1]),
        .clr_pulse (hdr_clr)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (sel)
                SEL_CTRL: bus_rdata[0] = irq;
                SEL_BUS:  bus_rdata[0] = s_q.own;
                SEL_MODE: begin
                    bus_rdata[0] = s_q.mode;
                    bus_rdata[1] = irq && !s_q.mode;
                end
                SEL_RUN: begin
                    bus_rdata[0] = s_q.run;
                    bus_rdata[1] = eng_busy;
                end
                default: ;
            endcase
        end
    end

    assign eng_enable    = s_q.en;
    assign eng_mode_play = s_q.mode;
    assign eng_dir_play  = s_q.dir;
    assign eng_bus_own   = s_q.own;
    assign eng_run       = s_q.run;
    assign eng_soft_rst  = ~s_q.run;
    assign eng_skip      = s_q.skip;
    assign cpu_irq       = irq;

    // R8: soft reset never coexists with a pending interrupt or bus hand-over
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_run |-> (!cpu_irq && !eng_bus_own));
    // R5: transfer-done releases the bus when no write intervenes
    a_r5_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xfer_done && !bus_wr) |=> !eng_bus_own);
    // R10: an outside write leaves the control state alone
    a_r10_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit && !eng_xfer_done) |=>
            ($stable(eng_enable) && $stable(eng_mode_play) && $stable(eng_run)
             && $stable(eng_skip) && $stable(eng_dir_play) && $stable(eng_bus_own)));
    // R10: idle bus reads zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sim_aud_ctl_regs.sv
module sim_aud_ctl_regs;
    localparam int ADDR_W = 8;
    localparam logic [7:0] BASE = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic       eng_irq_set = 1'b0, eng_xfer_done = 1'b0, eng_busy = 1'b0;
    logic       eng_enable, eng_mode_play, eng_dir_play, eng_bus_own;
    logic       eng_run, eng_soft_rst, eng_skip, hdr_clr, cpu_irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    bit m_en, m_mode, m_dir, m_run, m_skip, m_own, m_irq, m_arm, m_hdr;

    always #2 clk = ~clk;

    aud_ctl_regs #(.ADDR_W(ADDR_W), .BASE(BASE)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [7:0] a, input bit rd, input bit busy);
        logic [7:0] r = '0;
        if (!rd || a[7:2] != BASE[7:2]) return r;
        case (a[1:0])
            2'd0: r[0] = m_irq;
            2'd1: r[0] = m_own;
            2'd2: begin r[0] = m_mode; r[1] = m_irq && !m_mode; end
            default: begin r[0] = m_run; r[1] = busy; end
        endcase
        return r;
    endfunction

    // advance the model by one clock edge for the inputs now applied
    task automatic model_step();
        bit hit = (bus_addr[7:2] == BASE[7:2]);
        bit wr = bus_wr && hit, rd = bus_rd && hit;
        bit n_run = m_run, n_own = m_own, n_irq = m_irq, n_hdr = 0;
        if (wr && bus_addr[1:0] == 2'd3) n_run = bus_wdata[0];
        if (eng_xfer_done) n_own = 1'b0;
        if (wr && bus_addr[1:0] == 2'd1) n_own = bus_wdata[0];
        if (!n_run) n_own = 1'b0;
        if (rd && bus_addr[1:0] == 2'd0 && !m_mode) n_irq = 1'b0;
        if (eng_irq_set && m_run) n_irq = 1'b1;
        if (!n_run) n_irq = 1'b0;
        if (wr) case (bus_addr[1:0])
            2'd0: m_en = !bus_wdata[0];
            2'd1: m_dir = bus_wdata[1];
            2'd2: begin
                m_mode = bus_wdata[0];
                n_hdr = !bus_wdata[1] && m_arm;
                m_arm = bus_wdata[1];
            end
            default: m_skip = bus_wdata[1];
        endcase
        m_run = n_run; m_own = n_own; m_irq = n_irq; m_hdr = n_hdr;
    endtask

    task automatic check_outs(input string tag);
        chk({tag, " R2 enable"}, eng_enable, m_en);
        chk({tag, " R6 mode"}, eng_mode_play, m_mode);
        chk({tag, " R5 dir"}, eng_dir_play, m_dir);
        chk({tag, " R5 own"}, eng_bus_own, m_own);
        chk({tag, " R8 run"}, eng_run, m_run);
        chk({tag, " R8 softrst"}, eng_soft_rst, !m_run);
        chk({tag, " R9 skip"}, eng_skip, m_skip);
        chk({tag, " R7 hdr_clr"}, hdr_clr, m_hdr);
        chk({tag, " R3 irq"}, cpu_irq, m_irq);
    endtask

    // drive one cycle at the negedge, check read data, model the coming edge
    task automatic cyc(input bit rd, input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input bit iset, input bit done, input bit busy, input string tag);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        eng_irq_set = iset; eng_xfer_done = done; eng_busy = busy;
        #1;
        if (rd) chk({tag, " R10 rdata"}, bus_rdata, exp_rdata(a, rd, busy));
        model_step();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; eng_irq_set = 0; eng_xfer_done = 0;
        #1;
        chk({tag, " R10 idle rdata"}, bus_rdata, 0);
        check_outs(tag);
        model_step();
    endtask

    task automatic wr_reg(input logic [1:0] o, input logic [7:0] d, input string tag);
        cyc(0, 1, {BASE[7:2], o}, d, 0, 0, 0, tag);
    endtask

    task automatic rd_reg(input logic [1:0] o, input bit iset, input bit busy, input string tag);
        cyc(1, 0, {BASE[7:2], o}, 8'h00, iset, 0, busy, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check_outs("R1 reset");
        for (int i = 0; i < 4; i++) rd_reg(2'(i), 0, 0, "R1 reset read");

        // R2 active-low enable
        wr_reg(0, 8'h00, "R2 en0");
        chk("R2 enable after 0", eng_enable, 1);
        wr_reg(0, 8'h01, "R2 en1");
        chk("R2 enable after 1", eng_enable, 0);

        // start sequence, record mode
        wr_reg(3, 8'h00, "R8 reset");
        wr_reg(2, 8'h00, "R6 mode rec");
        wr_reg(3, 8'h01, "R8 start");
        chk("R8 running", eng_run, 1);

        // R3 irq set and clear-on-read in record mode
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, "R3 set");
        chk("R3 irq level", cpu_irq, 1);
        rd_reg(2, 0, 0, "R6 status read");
        rd_reg(0, 0, 0, "R3 clear read");
        chk("R3 irq cleared", cpu_irq, 0);
        // R4 race
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, "R4 pre");
        rd_reg(0, 1, 0, "R4 race");
        chk("R4 set wins", cpu_irq, 1);
        // R3 playback read does not clear
        wr_reg(2, 8'h01, "R6 play");
        rd_reg(2, 0, 0, "R6 play status zero");
        rd_reg(0, 0, 0, "R3 play read");
        chk("R3 irq kept in play", cpu_irq, 1);

        // R8 soft reset clears irq and ownership, ignores set
        wr_reg(1, 8'h03, "R5 own");
        rd_reg(1, 0, 0, "R5 own read");
        chk("R5 dir", eng_dir_play, 1);
        wr_reg(3, 8'h00, "R8 stop");
        chk("R8 irq cleared", cpu_irq, 0);
        chk("R8 own cleared", eng_bus_own, 0);
        cyc(0, 0, 8'h00, 8'h00, 1, 0, 0, "R8 ignored set");
        chk("R8 set ignored", cpu_irq, 0);
        wr_reg(3, 8'h01, "R8 restart");

        // R5 done clears
        wr_reg(1, 8'h01, "R5 own2");
        cyc(0, 0, 8'h00, 8'h00, 0, 1, 0, "R5 done");
        chk("R5 released", eng_bus_own, 0);

        // R7 header pulse rules
        wr_reg(2, 8'h00, "R7 plain zero");
        chk("R7 no pulse", hdr_clr, 0);
        wr_reg(2, 8'h02, "R7 arm");
        @(negedge clk);
        bus_wr = 1; bus_addr = {BASE[7:2], 2'd2}; bus_wdata = 8'h00;
        model_step();
        @(negedge clk); bus_wr = 0;
        chk("R7 pulse", hdr_clr, 1);
        model_step();
        @(negedge clk);
        chk("R7 one cycle", hdr_clr, 0);
        model_step();

        // R9 busy and skip
        rd_reg(3, 0, 1, "R9 busy");
        wr_reg(3, 8'h03, "R9 skip");
        chk("R9 skip on", eng_skip, 1);

        // R10 outside address and unused bits
        cyc(0, 1, 8'h44, 8'h00, 0, 0, 0, "R10 outside write");
        cyc(1, 0, 8'h3f, 8'h00, 0, 0, 1, "R10 outside read");
        wr_reg(0, 8'hfe, "R10 unused bits");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 9);
            logic [7:0] a = (k < 8) ? {BASE[7:2], 2'($urandom_range(0, 3))} : 8'($urandom);
            bit wr = ($urandom_range(0, 2) == 0);
            bit rd = !wr && ($urandom_range(0, 1) == 1);
            logic [7:0] d = 8'($urandom);
            if (wr && a[1:0] == 2'd3 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
            cyc(rd, wr, a, d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                1'($urandom), "rand");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule